// File: doc/BRIEF.md
# Carry-Save Array Multiplier

An unsigned N×N multiplier built as a rectangular array. Every bit pair of the two operands is ANDed into a partial-product matrix. The rows of that matrix are then folded in one at a time by rows of full adders. Each row keeps its result as two separate vectors, a sum and a carry, and lets no carry ripple inside the row. Each row also settles one low-order product bit. After the last row, one N-bit carry-propagate adder merges the remaining sum vector with the carry vector to form the upper half of the 2N-bit product.

The carry-save rows (`g_row[*].g_csa.u_csa_row`) and the closing adder (`u_final_cpa`) are separate instances in the hierarchy. The closing adder is a parameterized module with two variants: an explicit ripple chain and a behavioural adder. A faster structure can replace it without touching the array. A parameter selects a registered output stage, which is qualified by a valid strobe, or a purely combinational output.

Top module: `csamul_array`

## Requirements
- R1: With the output stage enabled, a cycle in which `in_valid` is high at a rising clock edge makes `product` equal to the unsigned product of that cycle's `mcand` and `mplier`, 2N bits wide, after that edge.
- R2: With the output stage enabled, `out_valid` equals the value `in_valid` had at the previous rising edge, which gives a latency of exactly one clock.
- R3: The closing adder never produces a carry out of its N bits. The upper N product bits equal the integer quotient of the full product divided by 2^N.
- R4: With the output stage enabled, a rising edge with `in_valid` low leaves `product` unchanged and drives `out_valid` low. A new operand pair applied during such a cycle has no effect on `product`.
- R5: While `rst_n` is low, and until the first accepted operand pair, `out_valid` is 0 and `product` is 0.
- R6: Boundary operands give exact results: a zero operand gives 0, and all-ones operands give (2^N−1)², which is 16'hFE01 for N=8 and 24'hFFE001 for N=12.
- R7: With the output stage disabled, `product` is the unsigned product of the operands currently applied, whatever the state of `in_valid`, and `out_valid` follows `in_valid` in the same cycle.
- R8: The ripple variant and the behavioural variant of the closing adder give identical products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| in_valid | input | 1 | Marks the operand pair as one to be captured |
| mcand | input | N | Multiplicand, unsigned |
| mplier | input | N | Multiplier, unsigned |
| out_valid | output | 1 | Marks `product` as holding a fresh result |
| product | output | 2N | Unsigned product |

## Verification
Two things meet on the same edge when valid operand pairs arrive back to back: the array computes a new product while the previous one is still being presented. The same happens when a valid pair is followed at once by a stalled cycle that carries different operands. The bench interleaves the valid strobe irregularly across an exhaustive sweep of 8-bit operands. A behavioural model then judges every cycle: on a capture edge the new product must appear, and on a stalled edge the held value must stay. A second, combinational instance at N=12 with the behavioural closing adder runs on random operands alongside.

// File: rtl/csamul_pkg.sv
package csamul_pkg;

   typedef enum logic [0:0] {
      CPA_RIPPLE = 1'b0,
      CPA_BEHAV  = 1'b1
   } cpa_kind_e;

   function automatic int unsigned prod_width(input int unsigned n);
      return 2 * n;
   endfunction

endpackage

// File: rtl/csamul_fa.sv
module csamul_fa (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co
);
   logic p;
   assign p  = a ^ b;
   assign s  = p ^ ci;
   assign co = (a & b) | (ci & p);
endmodule

// File: rtl/csamul_pp_gen.sv
module csamul_pp_gen #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0]   mcand,
   input  logic [N-1:0]   mplier,
   output logic [N*N-1:0] pp
);
   // row j holds mcand AND mplier[j]; bit i of row j has weight i+j
   for (genvar j = 0; j < N; j++) begin : g_pp_row
      for (genvar i = 0; i < N; i++) begin : g_pp_bit
         assign pp[j*N + i] = mcand[i] & mplier[j];
      end
   end
endmodule

// File: rtl/csamul_csa_row.sv
module csamul_csa_row #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic [W-1:0] z,
   output logic [W-1:0] s,
   output logic [W-1:0] c
);
   // three vectors in, two out; carries leave the row instead of rippling
   for (genvar i = 0; i < W; i++) begin : g_bit
      csamul_fa u_fa (
         .a  (x[i]),
         .b  (y[i]),
         .ci (z[i]),
         .s  (s[i]),
         .co (c[i])
      );
   end
endmodule

// File: rtl/csamul_cpa.sv
module csamul_cpa
   import csamul_pkg::*;
#(
   parameter int unsigned W    = 8,
   parameter cpa_kind_e   KIND = CPA_RIPPLE
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   if (W < 1) begin : g_bad_w
      $error("csamul_cpa: W must be at least 1");
   end

   if (KIND == CPA_RIPPLE) begin : g_ripple
      logic [W:0] cy;
      assign cy[0] = cin;
      for (genvar i = 0; i < W; i++) begin : g_stage
         csamul_fa u_fa (
            .a  (a[i]),
            .b  (b[i]),
            .ci (cy[i]),
            .s  (sum[i]),
            .co (cy[i+1])
         );
      end
      assign cout = cy[W];
   end else begin : g_behav
      logic [W:0] wide;
      assign wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      assign sum  = wide[W-1:0];
      assign cout = wide[W];
   end
endmodule

// File: rtl/csamul_array.sv
module csamul_array
   import csamul_pkg::*;
#(
   parameter int unsigned N        = 8,
   parameter int unsigned OUT_REG  = 1,
   parameter cpa_kind_e   CPA_KIND = CPA_RIPPLE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [N-1:0]      mcand,
   input  logic [N-1:0]      mplier,
   output logic              out_valid,
   output logic [2*N-1:0]    product
);
   localparam int unsigned PW = prod_width(N);

   if (N < 2) begin : g_bad_n
      $error("csamul_array: N must be at least 2");
   end
   if (OUT_REG > 1) begin : g_bad_reg
      $error("csamul_array: OUT_REG must be 0 or 1");
   end

   logic [N*N-1:0] pp;
   logic [N-1:0]   row_s [N];
   logic [N-1:0]   row_c [N];
   logic [N-1:0]   low_bits;
   logic [N-1:0]   high_bits;
   logic           cpa_cout;
   logic [PW-1:0]  comb_prod;

   csamul_pp_gen #(.N(N)) u_pp_gen (
      .mcand  (mcand),
      .mplier (mplier),
      .pp     (pp)
   );

   // row j is aligned at weight j: sum bit i has weight j+i, carry bit i weight j+i+1
   for (genvar j = 0; j < N; j++) begin : g_row
      if (j == 0) begin : g_first
         assign row_s[0] = pp[N-1:0];
         assign row_c[0] = '0;
      end else begin : g_csa
         logic [N-1:0] y_in;
         assign y_in = {1'b0, row_s[j-1][N-1:1]};
         csamul_csa_row #(.W(N)) u_csa_row (
            .x (pp[j*N +: N]),
            .y (y_in),
            .z (row_c[j-1]),
            .s (row_s[j]),
            .c (row_c[j])
         );
      end
      // lowest sum bit of each row is final: one product bit retires per row
      assign low_bits[j] = row_s[j][0];
   end

   csamul_cpa #(.W(N), .KIND(CPA_KIND)) u_final_cpa (
      .a    ({1'b0, row_s[N-1][N-1:1]}),
      .b    (row_c[N-1]),
      .cin  (1'b0),
      .sum  (high_bits),
      .cout (cpa_cout)
   );

   assign comb_prod = {high_bits, low_bits};

   if (OUT_REG == 1) begin : g_reg
      logic [PW-1:0] prod_q;
      logic          vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prod_q <= '0;
            vld_q  <= 1'b0;
         end else begin
            vld_q <= in_valid;
            if (in_valid) begin
               prod_q <= comb_prod;
            end
         end
      end
      assign product   = prod_q;
      assign out_valid = vld_q;
   end else begin : g_comb
      assign product   = comb_prod;
      assign out_valid = in_valid;
   end
endmodule

// File: rtl/csamul_array_chk.sv
module csamul_array_chk #(
   parameter int unsigned N       = 8,
   parameter int unsigned OUT_REG = 1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic [N-1:0]   mcand,
   input logic [N-1:0]   mplier,
   input logic           out_valid,
   input logic [2*N-1:0] product,
   input logic           cpa_cout
);
   logic [2*N-1:0] ref_prod;
   logic           armed;

   assign ref_prod = {{N{1'b0}}, mcand} * {{N{1'b0}}, mplier};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cpa_cout);

   if (OUT_REG == 1) begin : g_reg_props
      assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         out_valid == $past(in_valid));

      assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         $past(in_valid) |-> product == $past(ref_prod));

      assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         !$past(in_valid) |-> $stable(product));

      always @(negedge clk) begin
         if (!rst_n) begin
            assert_reset_R5: assert (!out_valid && product == '0);
         end
      end
   end else begin : g_comb_props
      assert_comb_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (product == ref_prod) && (out_valid == in_valid));
   end
endmodule

bind csamul_array csamul_array_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .mcand     (mcand),
   .mplier    (mplier),
   .out_valid (out_valid),
   .product   (product),
   .cpa_cout  (cpa_cout)
);

// File: tb/csamul_array_bench.sv
module csamul_array_bench;
   import csamul_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk   = 1'b0;
   logic        rst_n = 1'b0;

   logic        v8 = 1'b0;
   logic [7:0]  a8 = '0;
   logic [7:0]  b8 = '0;
   logic        ov8;
   logic [15:0] p8;

   logic        v12 = 1'b0;
   logic [11:0] a12 = '0;
   logic [11:0] b12 = '0;
   logic        ov12;
   logic [23:0] p12;

   int tests = 0;
   int fails = 0;

   logic        exp_valid = 1'b0;
   logic [15:0] exp_prod  = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   csamul_array #(.N(8), .OUT_REG(1), .CPA_KIND(CPA_RIPPLE)) u_csamul_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (v8),
      .mcand     (a8),
      .mplier    (b8),
      .out_valid (ov8),
      .product   (p8)
   );

   csamul_array #(.N(12), .OUT_REG(0), .CPA_KIND(CPA_BEHAV)) u_csamul_array_c12 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (v12),
      .mcand     (a12),
      .mplier    (b12),
      .out_valid (ov12),
      .product   (p12)
   );

   // behavioural model of the registered 8-bit instance
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_valid = 1'b0;
         exp_prod  = '0;
      end else begin
         exp_valid = v8;
         if (v8) exp_prod = 16'(a8) * 16'(b8);
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
   endtask

   task automatic tick_check();
      logic [23:0] e12;
      @(negedge clk);
      e12 = 24'(a12) * 24'(b12);
      chk(ov8 == exp_valid, "R2", 32'(ov8), 32'(exp_valid));
      chk(p8 == exp_prod, exp_valid ? "R1" : "R4", 32'(p8), 32'(exp_prod));
      chk(p12 == e12, "R8", 32'(p12), 32'(e12));
      chk(ov12 == v12, "R7", 32'(ov12), 32'(v12));
   endtask

   task automatic drive(input logic v, input logic [7:0] a, input logic [7:0] b,
                        input logic [11:0] c, input logic [11:0] d);
      v8  = v;
      a8  = a;
      b8  = b;
      v12 = ~v;
      a12 = c;
      b12 = d;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      chk(1'b0, "R1 watchdog", 32'd0, 32'd1);
      summary();
      $finish;
   end

   initial begin
      // R5: reset state, with a valid pair presented during reset
      drive(1'b1, 8'h5A, 8'hC3, 12'h000, 12'h000);
      repeat (3) begin
         @(negedge clk);
         chk(ov8 == 1'b0, "R5", 32'(ov8), 32'd0);
         chk(p8 == 16'h0, "R5", 32'(p8), 32'd0);
      end
      drive(1'b0, 8'h00, 8'h00, 12'h000, 12'h000);
      @(negedge clk);
      rst_n = 1'b1;
      tick_check();
      chk(p8 == 16'h0, "R5", 32'(p8), 32'd0);
      chk(ov8 == 1'b0, "R5", 32'(ov8), 32'd0);

      // R1 R2 R4 R7 R8: exhaustive 8-bit sweep with an irregular strobe
      for (int ia = 0; ia < 256; ia++) begin
         for (int ib = 0; ib < 256; ib++) begin
            drive(((ia * 256 + ib) % 5) != 2, 8'(ia), 8'(ib),
                  12'($urandom_range(0, 4095)), 12'($urandom_range(0, 4095)));
            tick_check();
         end
      end

      // R6 R3: all-ones operands
      drive(1'b1, 8'hFF, 8'hFF, 12'hFFF, 12'hFFF);
      tick_check();
      chk(p8 == 16'hFE01, "R6", 32'(p8), 32'hFE01);
      chk(p8[15:8] == 8'hFE, "R3", 32'(p8[15:8]), 32'hFE);
      chk(p12 == 24'hFFE001, "R6", 32'(p12), 32'hFFE001);

      // R4: stalled cycle with new operands must not disturb the held product
      drive(1'b0, 8'h12, 8'h34, 12'h800, 12'h003);
      tick_check();
      chk(p8 == 16'hFE01, "R4", 32'(p8), 32'hFE01);
      chk(ov8 == 1'b0, "R4", 32'(ov8), 32'd0);

      // R6: zero operand
      drive(1'b1, 8'h00, 8'h99, 12'h000, 12'hABC);
      tick_check();
      chk(p8 == 16'h0, "R6", 32'(p8), 32'd0);
      chk(p12 == 24'h0, "R6", 32'(p12), 32'd0);
      drive(1'b1, 8'h80, 8'h02, 12'h001, 12'hFFF);
      tick_check();
      chk(p8 == 16'h0100, "R1", 32'(p8), 32'h100);
      drive(1'b0, 8'h00, 8'h00, 12'h000, 12'h000);
      tick_check();

      summary();
      $finish;
   end
endmodule